// File: doc/BRIEF.md
# Four-Word Serial PCM Test Pattern Generator

This block produces the serial test data for one channel time slot of a 2.048 Mb/s PCM transmit path. Once per 125 us frame an external timing block raises a slot window for eight bit periods. During that window the generator shifts out one 8-bit word, most significant bit first, one bit per bit strobe. Outside the window the line rests at logic 1. The output is a registered version of the selected bit, gated by the window and retimed on the fast system clock. The bit clock is therefore presented as a one-cycle strobe `bit_stb` within that clock domain.

Two pattern modes exist. In single-word mode the programmable word goes out in every frame. In four-word mode the generator walks through a cycle of four words, one per frame: the programmable word, then three marker words that each carry a single 1 bit. The cycle restarts on a word-sync pulse that arrives once every four frames. In a looped-back system the marker words make the receive-side latency, counted in frames, directly readable. The mode input is only taken at a word-sync pulse, so a cycle in progress is never disturbed.

Top module: `pcm_pattern_gen`

## Requirements
- R1: After synchronous reset, `ser_out` is 1, the word pointer is at word 0 and the generator is in single-word mode, until a `word_sync` pulse arrives.
- R2: A `bit_stb` while `slot_win` is low drives `ser_out` to 1 one clock later. `ser_out` changes only on the clock edge that follows a `bit_stb`.
- R3: Each `bit_stb` while `slot_win` is high outputs one bit of the current word. Bit 7 (MSB) goes first and bit 0 last, and `ser_out` takes the bit on the edge after the strobe.
- R4: In single-word mode (latched mode value 0), every burst carries the value of `prog_word` present at each strobe.
- R5: In four-word mode (latched mode value 1), successive complete 8-bit bursts carry `prog_word`, 8'h80, 8'h01 and 8'h10, and then wrap back to `prog_word`.
- R6: `four_word_mode` is sampled only on a clock edge where `word_sync` is 1. A change between sync pulses has no effect on the bursts that follow.
- R7: A `word_sync` pulse returns the word pointer to word 0, so the next burst carries `prog_word`.
- R8: When `word_sync` falls in the same clock as the eighth strobe of a burst, the sync takes priority. The next burst carries word 0, not the following word.
- R9: A burst cut short (window low before eight strobes) does not advance the word pointer. The next burst restarts at the MSB of the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (four times the bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking each 2.048 Mb/s bit period |
| slot_win | input | 1 | Transmit time-slot window, high for eight bit periods per frame |
| word_sync | input | 1 | One-cycle pulse once per four frames; restarts the cycle and latches the mode |
| prog_word | input | 8 | Programmable word 0 |
| four_word_mode | input | 1 | 1 selects the four-word cycle, 0 selects single-word repetition |
| ser_out | output | 1 | Serial test data, MSB first, 1 when idle |

## Verification
The word pointer has two sources of change: the advance at the end of a complete burst and the restart from `word_sync`. Both can land on the same clock edge. The bench provokes this by raising `word_sync` together with the eighth strobe of a burst in four-word mode. It then judges the outcome at the port: the next burst must repeat the programmable word, and the burst after it must be the 8'h80 marker. A second overlap is a mode change on the sync edge, which must switch the pattern from the very next burst. The bench checks this both on entry to and exit from four-word mode.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    localparam int WORD_W    = 8;
    localparam int NUM_WORDS = 4;
    localparam int SEL_W     = $clog2(NUM_WORDS);
    localparam int BIT_W     = $clog2(WORD_W);

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CYCLE  = 1'b1
    } pgen_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        pgen_mode_e       mode;
    } pgen_seq_t;

    // Marker words: one set bit each, at MSB, LSB and mid position.
    function automatic logic [WORD_W-1:0] marker_word(input logic [SEL_W-1:0] sel);
        logic [WORD_W-1:0] w;
        w = '0;
        case (sel)
            SEL_W'(1): w[WORD_W-1]   = 1'b1;
            SEL_W'(2): w[0]          = 1'b1;
            SEL_W'(3): w[WORD_W/2]   = 1'b1;
            default:   w             = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pgen_bit_ctr.sv
module pgen_bit_ctr
    import pgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             slot_win,
    output logic [BIT_W-1:0] bit_idx,
    output logic             burst_done
);

    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx <= '0;
        end else if (bit_stb) begin
            if (slot_win) begin
                bit_idx <= bit_idx + BIT_W'(1);
            end else begin
                bit_idx <= '0;
            end
        end
    end

    assign burst_done = bit_stb && slot_win && (bit_idx == LAST_IDX);

    // R9
    idx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !slot_win) |=> (bit_idx == '0));

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(bit_idx));

endmodule

// File: rtl/pgen_word_seq.sv
module pgen_word_seq
    import pgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      word_sync,
    input  logic      four_word_mode,
    input  logic      burst_done,
    output pgen_seq_t seq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq.sel  <= '0;
            seq.mode <= MODE_SINGLE;
        end else if (word_sync) begin
            seq.sel  <= '0;
            seq.mode <= four_word_mode ? MODE_CYCLE : MODE_SINGLE;
        end else if (burst_done && (seq.mode == MODE_CYCLE)) begin
            seq.sel  <= seq.sel + SEL_W'(1);
        end
    end

    // R7
    sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
        word_sync |=> (seq.sel == '0));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_sync |=> $stable(seq.mode));

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_sync && !burst_done) |=> $stable(seq.sel));

    // R4
    single_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (seq.mode == MODE_SINGLE) |-> (seq.sel == '0));

endmodule

// File: rtl/pcm_pattern_gen.sv
module pcm_pattern_gen
    import pgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              slot_win,
    input  logic              word_sync,
    input  logic [WORD_W-1:0] prog_word,
    input  logic              four_word_mode,
    output logic              ser_out
);

    localparam logic [BIT_W-1:0] MSB_POS = BIT_W'(WORD_W - 1);

    logic [BIT_W-1:0]  bit_idx;
    logic              burst_done;
    pgen_seq_t         seq;
    logic [WORD_W-1:0] cur_word;
    logic [BIT_W-1:0]  bit_pos;
    logic              gated_bit;

    pgen_bit_ctr u_bit_ctr (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .slot_win   (slot_win),
        .bit_idx    (bit_idx),
        .burst_done (burst_done)
    );

    pgen_word_seq u_word_seq (
        .clk            (clk),
        .rst            (rst),
        .word_sync      (word_sync),
        .four_word_mode (four_word_mode),
        .burst_done     (burst_done),
        .seq            (seq)
    );

    always_comb begin
        if ((seq.mode == MODE_CYCLE) && (seq.sel != '0)) begin
            cur_word = marker_word(seq.sel);
        end else begin
            cur_word = prog_word;
        end
    end

    assign bit_pos   = MSB_POS - bit_idx;
    assign gated_bit = slot_win ? cur_word[bit_pos] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out <= 1'b1;
        end else if (bit_stb) begin
            ser_out <= gated_bit;
        end
    end

    // R2
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !slot_win) |=> ser_out);

    // R2
    out_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(ser_out));

endmodule

// File: tb/pcm_pattern_gen_tb_top.sv
module pcm_pattern_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       slot_win = 1'b0;
    logic       word_sync = 1'b0;
    logic [7:0] prog_word = 8'hA9;
    logic       four_word_mode = 1'b0;
    logic       ser_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pcm_pattern_gen dut_i (
        .clk            (clk),
        .rst            (rst),
        .bit_stb        (bit_stb),
        .slot_win       (slot_win),
        .word_sync      (word_sync),
        .prog_word      (prog_word),
        .four_word_mode (four_word_mode),
        .ser_out        (ser_out)
    );

    function automatic logic [7:0] expect_word(input int k, input logic [7:0] p);
        case (k % 4)
            0:       return p;
            1:       return 8'd1 << 7;
            2:       return 8'd1;
            default: return 8'd1 << 4;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic strobe(input logic slot, input logic sync, output logic b);
        @(negedge clk);
        slot_win  = slot;
        bit_stb   = 1'b1;
        word_sync = sync;
        @(negedge clk);
        bit_stb   = 1'b0;
        word_sync = 1'b0;
        b = ser_out;
        repeat (2) @(negedge clk);
    endtask

    task automatic gap(input string tag);
        logic b;
        strobe(1'b0, 1'b0, b);
        check(tag, {7'd0, b}, 8'd1);
    endtask

    task automatic burst(input int nbits, input logic sync_last, output logic [7:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < nbits; i++) begin
            strobe(1'b1, sync_last && (i == nbits - 1), b);
            w = {w[6:0], b};
        end
    endtask

    task automatic pulse_sync(input logic mode);
        @(negedge clk);
        four_word_mode = mode;
        word_sync = 1'b1;
        @(negedge clk);
        word_sync = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] w;
        logic       b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state idle high
        check("R1 reset idle", {7'd0, ser_out}, 8'd1);
        // R1: single mode after reset without any sync
        burst(8, 1'b0, w); check("R1 default single", w, 8'hA9);
        gap("R2 gap");
        burst(8, 1'b0, w); check("R1 default single 2", w, 8'hA9);

        // R2: output holds between strobes
        gap("R2 gap before hold");
        repeat (6) @(negedge clk);
        check("R2 hold", {7'd0, ser_out}, 8'd1);

        // R3, R4: exhaustive sweep of programmable word, MSB first
        for (int v = 0; v < 256; v++) begin
            prog_word = 8'(v);
            gap("R2 sweep gap");
            burst(8, 1'b0, w);
            check("R3 R4 sweep", w, 8'(v));
        end

        // R6: mode raised without sync has no effect
        prog_word = 8'hA9;
        four_word_mode = 1'b1;
        for (int f = 0; f < 2; f++) begin
            gap("R2 gap");
            burst(8, 1'b0, w); check("R6 no sync", w, 8'hA9);
        end

        // R5: four-word cycle over three full cycles, several prog values
        for (int c = 0; c < 3; c++) begin
            prog_word = 8'(8'h3C + c * 8'h21);
            pulse_sync(1'b1);
            for (int k = 0; k < 4; k++) begin
                gap("R2 gap");
                burst(8, 1'b0, w);
                check("R5 cycle", w, expect_word(k, prog_word));
            end
        end
        // R5: wrap without sync
        prog_word = 8'hA9;
        for (int k = 0; k < 6; k++) begin
            gap("R2 gap");
            burst(8, 1'b0, w);
            check("R5 wrap", w, expect_word(k, prog_word));
        end

        // R7: sync mid-cycle restarts at word 0 (pointer now at word 2)
        pulse_sync(1'b1);
        gap("R2 gap");
        burst(8, 1'b0, w); check("R7 restart", w, 8'hA9);
        burst(8, 1'b0, w); check("R7 then marker", w, 8'h80);

        // R8: sync with the eighth strobe of word-2 burst beats the advance
        burst(8, 1'b1, w); check("R8 collided burst", w, 8'h01);
        gap("R2 gap");
        burst(8, 1'b0, w); check("R8 sync wins", w, 8'hA9);
        burst(8, 1'b0, w); check("R8 next marker", w, 8'h80);

        // R9: partial burst of word 0 does not advance
        pulse_sync(1'b1);
        burst(3, 1'b0, w); check("R9 partial msbs", w, {5'd0, 3'b101});
        gap("R9 gap");
        burst(8, 1'b0, w); check("R9 restart msb", w, 8'hA9);
        burst(5, 1'b0, w); check("R9 partial marker", w, 8'h10);
        gap("R9 gap2");
        burst(8, 1'b0, w); check("R9 marker repeat", w, 8'h80);

        // R6: mode lowered without sync keeps cycling
        four_word_mode = 1'b0;
        gap("R2 gap");
        burst(8, 1'b0, w); check("R6 still cycle", w, 8'h01);
        // R6: mode taken at sync, single from the next burst
        pulse_sync(1'b0);
        for (int f = 0; f < 3; f++) begin
            gap("R2 gap");
            burst(8, 1'b0, w); check("R6 single after sync", w, 8'hA9);
        end
        // R1: reset again returns to single mode with idle high
        four_word_mode = 1'b1;
        pulse_sync(1'b1);
        burst(8, 1'b0, w);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset idle again", {7'd0, ser_out}, 8'd1);
        burst(8, 1'b0, w); check("R1 single after reset", w, 8'hA9);
        burst(8, 1'b0, w); check("R1 single after reset 2", w, 8'hA9);
        strobe(1'b0, 1'b0, b);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule